// File: doc/BRIEF.md
# Address-Decoded Five-Port Arbitrated Crossbar

This block joins five input ports to five output ports in a single switching step. Each input offers a 16-bit message together with a request bit. The lowest three bits of the message name the output the message wants. Each output has its own arbiter. That arbiter looks only at the requesting inputs that name its port, and it picks one of them by fixed priority.

The winning message goes into that output's register and shows up, with a valid bit, one clock after the request. In the same clock each input gets back a grant bit that tells it whether its message went through. Outputs are independent, so up to five messages can cross in the same cycle when their destinations differ. The block does no buffering: a request that loses is simply not forwarded, and the requester has to hold it or present it again.

Top module: `addr_xbar`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every output valid bit, every output data word and every grant bit is zero.
- R2: A requesting input whose message has low bits equal to k (k from 1 to 5) and which wins arbitration has its full 16-bit message on output k-1 (output indices start at 0), with that output's valid bit set, one clock after the request.
- R3: An input whose request bit is low is never forwarded and never granted, whatever its message holds.
- R4: A request whose low three bits are 000, 110 or 111 is ignored: it is not granted and it makes no output valid.
- R5: When several inputs target the same output, the input with the lowest index wins. Input 0 has the highest priority and input 4 the lowest.
- R6: An output with no winner has its valid bit at 0 and its data at all zeros.
- R7: One clock after the request, an input's grant bit is 1 exactly when some output selected that input.
- R8: Each forwarded message is held for one cycle only. If no request targets the output in the next cycle, the output's valid bit drops to 0.
- R9: Requests aimed at different outputs are all served in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inData | input | 5x16 | Message of each input; bits [2:0] give the destination code |
| inReq | input | 5 | Request bit of each input |
| outData | output | 5x16 | Registered message of each output |
| outValid | output | 5 | Output carries a forwarded message |
| inGrant | output | 5 | Registered grant bit of each input |

## Verification
The sweep runs every one of the 32 request masks against many destination patterns, so the priority order gets tested whenever two or more inputs share an output. A reversed or rotated priority would send the wrong message to that output. Directed cases drive the three illegal destination codes: a decoder that masked only some of the code bits would forward such a request to a real port. A one-shot request followed by silence checks that the outputs go back to zero data and no valid, which catches a design that holds the last value. An all-idle request set carrying legal codes catches a design that decodes the destination but ignores the request bit.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int XBAR_PORTS = 5;
  localparam int DEST_W = $clog2(XBAR_PORTS + 1);

  typedef struct packed {
    logic [XBAR_PORTS-1:0][XBAR_PORTS-1:0] sel;     // per output, one-hot input select
    logic [XBAR_PORTS-1:0]                 hit;     // per output, a winner exists
    logic [XBAR_PORTS-1:0]                 inGrant; // per input, selected somewhere
  } xbar_strobe_t;
endpackage

// File: rtl/xbar_fp_arbiter.sv
module xbar_fp_arbiter #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb begin
    logic taken;
    taken = 1'b0;
    for (int i = 0; i < N; i++) begin
      gnt[i] = req[i] & ~taken;
      taken  = taken | req[i];
    end
  end
endmodule

// File: rtl/xbar_ctrl.sv
module xbar_ctrl
  import xbar_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [XBAR_PORTS-1:0][DATA_W-1:0] inData,
  input  logic [XBAR_PORTS-1:0]             inReq,
  output xbar_strobe_t                      strobe
);
  logic [XBAR_PORTS-1:0][DEST_W-1:0] destCode;
  logic [XBAR_PORTS-1:0][XBAR_PORTS-1:0] targetReq;  // [out][in]
  logic [XBAR_PORTS-1:0][XBAR_PORTS-1:0] outGnt;     // [out][in]

  for (genvar i = 0; i < XBAR_PORTS; i++) begin : g_decode
    assign destCode[i] = inData[i][DEST_W-1:0];
  end

  for (genvar o = 0; o < XBAR_PORTS; o++) begin : g_out
    for (genvar i = 0; i < XBAR_PORTS; i++) begin : g_in
      assign targetReq[o][i] = inReq[i] && (destCode[i] == DEST_W'(o + 1));
    end

    xbar_fp_arbiter #(.N(XBAR_PORTS)) arb (
      .req(targetReq[o]),
      .gnt(outGnt[o])
    );

    assign strobe.sel[o] = outGnt[o];
    assign strobe.hit[o] = |targetReq[o];
  end

  always_comb begin
    strobe.inGrant = '0;
    for (int o = 0; o < XBAR_PORTS; o++) begin
      strobe.inGrant = strobe.inGrant | outGnt[o];
    end
  end
endmodule

// File: rtl/xbar_datapath.sv
module xbar_datapath
  import xbar_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [XBAR_PORTS-1:0][DATA_W-1:0] inData,
  input  xbar_strobe_t                      strobe,
  output logic [XBAR_PORTS-1:0][DATA_W-1:0] outData,
  output logic [XBAR_PORTS-1:0]             outValid,
  output logic [XBAR_PORTS-1:0]             inGrant
);
  logic [XBAR_PORTS-1:0][DATA_W-1:0] muxData;

  for (genvar o = 0; o < XBAR_PORTS; o++) begin : g_mux
    always_comb begin
      muxData[o] = '0;
      for (int i = 0; i < XBAR_PORTS; i++) begin
        muxData[o] = muxData[o] | (inData[i] & {DATA_W{strobe.sel[o][i]}});
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outData[o]  <= '0;
        outValid[o] <= 1'b0;
      end else begin
        outData[o]  <= muxData[o];
        outValid[o] <= strobe.hit[o];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inGrant <= '0;
    else       inGrant <= strobe.inGrant;
  end
endmodule

// File: rtl/addr_xbar.sv
module addr_xbar
  import xbar_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [XBAR_PORTS-1:0][DATA_W-1:0] inData,
  input  logic [XBAR_PORTS-1:0]             inReq,
  output logic [XBAR_PORTS-1:0][DATA_W-1:0] outData,
  output logic [XBAR_PORTS-1:0]             outValid,
  output logic [XBAR_PORTS-1:0]             inGrant
);
  xbar_strobe_t strobe;

  xbar_ctrl #(.DATA_W(DATA_W)) ctrl (
    .inData(inData),
    .inReq(inReq),
    .strobe(strobe)
  );

  xbar_datapath #(.DATA_W(DATA_W)) dp (
    .clk(clk),
    .rstN(rstN),
    .inData(inData),
    .strobe(strobe),
    .outData(outData),
    .outValid(outValid),
    .inGrant(inGrant)
  );
endmodule

// File: rtl/addr_xbar_checker.sv
module addr_xbar_checker
  import xbar_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic                              clk,
  input logic                              rstN,
  input logic [XBAR_PORTS-1:0][DATA_W-1:0] inData,
  input logic [XBAR_PORTS-1:0]             inReq,
  input logic [XBAR_PORTS-1:0][DATA_W-1:0] outData,
  input logic [XBAR_PORTS-1:0]             outValid,
  input logic [XBAR_PORTS-1:0]             inGrant
);
  AST_GRANT_MATCHES_VALID: assert property (@(posedge clk) disable iff (!rstN)
    $countones(inGrant) == $countones(outValid)); // R7

  for (genvar o = 0; o < XBAR_PORTS; o++) begin : g_o
    AST_IDLE_OUTPUT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      !outValid[o] |-> outData[o] == '0); // R6
  end

  for (genvar i = 0; i < XBAR_PORTS; i++) begin : g_i
    AST_NO_REQ_NO_GRANT: assert property (@(posedge clk) disable iff (!rstN)
      !inReq[i] |=> !inGrant[i]); // R3

    AST_BAD_CODE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
      (inReq[i] && (inData[i][DEST_W-1:0] == '0 ||
                    inData[i][DEST_W-1:0] > DEST_W'(XBAR_PORTS)))
      |=> !inGrant[i]); // R4

    for (genvar o = 0; o < XBAR_PORTS; o++) begin : g_t
      AST_TARGET_VALID: assert property (@(posedge clk) disable iff (!rstN)
        (inReq[i] && inData[i][DEST_W-1:0] == DEST_W'(o + 1)) |=> outValid[o]); // R2
    end
  end

  AST_TOP_PRIORITY_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (inReq[0] && inData[0][DEST_W-1:0] != '0 &&
     inData[0][DEST_W-1:0] <= DEST_W'(XBAR_PORTS)) |=> inGrant[0]); // R5
endmodule

bind addr_xbar addr_xbar_checker #(.DATA_W(DATA_W)) chk (
  .clk(clk),
  .rstN(rstN),
  .inData(inData),
  .inReq(inReq),
  .outData(outData),
  .outValid(outValid),
  .inGrant(inGrant)
);

// File: tb/addr_xbar_test.sv
module addr_xbar_test;
  localparam int P = 5;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [P-1:0][W-1:0] inData = '0;
  logic [P-1:0]        inReq = '0;
  logic [P-1:0][W-1:0] outData;
  logic [P-1:0]        outValid;
  logic [P-1:0]        inGrant;

  int nTests = 0;
  int nFail = 0;
  bit finished = 1'b0;

  logic [P-1:0][W-1:0] expData;
  logic [P-1:0]        expValid;
  logic [P-1:0]        expGrant;

  always #2 clk = ~clk;

  addr_xbar #(.DATA_W(W)) uut (
    .clk(clk), .rstN(rstN), .inData(inData), .inReq(inReq),
    .outData(outData), .outValid(outValid), .inGrant(inGrant)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference: per output, lowest index requester with matching code
  task automatic model();
    expData = '0; expValid = '0; expGrant = '0;
    for (int o = 0; o < P; o++) begin
      for (int i = 0; i < P; i++) begin
        if (!expValid[o] && inReq[i] && int'(inData[i][2:0]) == o + 1) begin
          expValid[o] = 1'b1;
          expData[o] = inData[i];
          expGrant[i] = 1'b1;
        end
      end
    end
  endtask

  // drive at negedge, observe one negedge later (after the capturing edge)
  task automatic step(input logic [P-1:0] req, input logic [P-1:0][W-1:0] d, input string tag);
    @(negedge clk);
    inReq = req; inData = d;
    model();
    @(negedge clk);
    for (int o = 0; o < P; o++) begin
      chk({tag, " R2 valid"}, W'(outValid[o]), W'(expValid[o]));
      chk(expValid[o] ? {tag, " R2 data"} : {tag, " R6 idle data"}, outData[o], expData[o]);
    end
    chk({tag, " R7 grant"}, W'(inGrant), W'(expGrant));
  endtask

  function automatic logic [W-1:0] msg(input int tagv, input int code);
    return {13'(tagv), 3'(code)};
  endfunction

  initial begin
    logic [P-1:0][W-1:0] d;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", W'(outValid), '0);
    chk("R1 grant in reset", W'(inGrant), '0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", W'(outValid), '0);
    chk("R1 data after reset", outData[2], '0);

    // R9: one input per output, all served together
    for (int i = 0; i < P; i++) d[i] = msg(100 + i, P - i);
    step('1, d, "R9 parallel");
    chk("R9 all valid", W'(outValid), W'(5'b11111));

    // R8: drop requests, outputs clear next cycle
    step('0, d, "R8 release");
    chk("R8 valid dropped", W'(outValid), '0);

    // R3: legal codes but no request
    for (int i = 0; i < P; i++) d[i] = msg(200 + i, i + 1);
    step('0, d, "R3 no request");
    chk("R3 grants zero", W'(inGrant), '0);

    // R4: illegal codes 0, 6, 7 on all inputs
    for (int c = 0; c < 8; c++) begin
      if (c == 0 || c > P) begin
        for (int i = 0; i < P; i++) d[i] = msg(300 + i + c, c);
        step('1, d, "R4 bad code");
        chk("R4 no valid", W'(outValid), '0);
        chk("R4 no grant", W'(inGrant), '0);
      end
    end

    // R5: all inputs to each output in turn
    for (int o = 0; o < P; o++) begin
      for (int i = 0; i < P; i++) d[i] = msg(400 + i, o + 1);
      step('1, d, "R5 contend");
      chk("R5 winner is input 0", W'(inGrant), W'(5'b00001));
      step(5'b11100, d, "R5 contend low");
      chk("R5 winner is input 2", W'(inGrant), W'(5'b00100));
    end

    // sweep: every request mask against many destination patterns
    for (int s = 0; s < 160; s++) begin
      for (int m = 0; m < 32; m++) begin
        for (int i = 0; i < P; i++)
          d[i] = msg(s * 37 + m * 5 + i * 911, (s * 7 + i * (s + 3) + m) % 8);
        step(5'(m), d, "sweep");
      end
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule